// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt lines, holds them in a request register, and filters them through a mask register and an in-service register. It signals the processor when an unmasked request outranks everything already being serviced. On an acknowledge strobe it returns an 8-bit vector. The vector's upper bits come from a programmed base and its lower three bits are the winning input number. Software talks to it through two byte ports: a command port (`addr`=0) and a data port (`addr`=1). The block is programmed with the classic four-byte initialization sequence and with end-of-interrupt and read-select command bytes.

Two instances can be chained. The master marks its cascaded inputs during initialization. When such an input wins an acknowledge, the master drives the input number on the cascade bus, and the slave whose programmed identity matches supplies the vector. A request that vanishes before it is acknowledged produces the lowest-priority vector (input 7) and changes no in-service bit, so software can recognise it as spurious.

Top module: `pic_core`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask is 0xFF, `int_out` is low, and the block waits for the first initialization byte.
- R2: A command-port write with bit 4 set starts initialization and clears the in-service register. The following data-port writes are taken in order: the vector base, then the cascade byte (only when bit 1 of the first byte is 0), then the mode byte (only when bit 0 of the first byte is 1). Data-port writes made before any initialization has started are ignored, and the mask stays 0xFF.
- R3: `vec_vld` is high for exactly the cycle after a selected `inta` cycle, with `vec` = {base[7:3], input number}.
- R4: Priority is fixed, with input 0 the highest. `int_out` is high only after initialization and only when some unmasked request has a higher priority than every set in-service bit.
- R5: An input whose `level_sel` bit is 0 is edge-triggered: its request bit sets on a rising input and clears either at its acknowledge or when the input falls. An input whose `level_sel` bit is 1 has a request bit that follows the input level.
- R6: When bit 1 of the mode byte is 0, an acknowledge sets the winner's in-service bit. When that bit is 1 (auto end of interrupt), an acknowledge leaves the in-service register unchanged.
- R7: A command byte 0x60+n clears in-service bit n only. A command byte 0x20 clears the highest-priority set in-service bit.
- R8: Command bytes 0x0A and 0x0B make later command-port reads return the request register or the in-service register respectively. The selection holds until it is changed, and initialization resets it to the request register.
- R9: After initialization, data-port writes load the mask and data-port reads return it.
- R10: An acknowledge with no qualifying request returns {base[7:3], 3'd7} and leaves the in-service register unchanged, even when input 7 is masked.
- R11: On a master (`is_master`=1) in cascade mode, an acknowledge won by an input marked in the cascade byte drives `cas_vld_out` and `cas_id_out` = input number, and produces no vector. A slave answers `inta` only while `cas_vld_in` is high and `cas_id_in` equals bits 2:0 of its cascade byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when `rd_en` is low) |
| irq_in | input | 8 | Interrupt request lines |
| level_sel | input | 8 | Per-input trigger select, 1 = level |
| is_master | input | 1 | 1 = master or stand-alone, 0 = slave |
| inta | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Acknowledge vector |
| vec_vld | output | 1 | Vector valid |
| cas_id_out | output | 3 | Cascade input number driven by a master |
| cas_vld_out | output | 1 | Cascade select valid |
| cas_id_in | input | 3 | Cascade number seen by a slave |
| cas_vld_in | input | 1 | Cascade select seen by a slave |

## Verification
The spurious acknowledge is the hardest case to reach. It needs an edge request that has latched, raised `int_out`, and then vanished before the strobe arrives. The stimulus raises a line, lets it register, drops it, and confirms through the request read-back that the bit is gone before it pulses `inta` while input 7 is masked. The cascade path is reached by wiring two instances in the bench. The slave's request line travels through the slave's `int_out` into master input 2, and the two end-of-interrupt commands then clear both in-service registers.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_NIN = 8;
    localparam int PIC_DW  = 8;
    localparam int PIC_IW  = $clog2(PIC_NIN);
    localparam int PIC_BW  = PIC_DW - PIC_IW;

    typedef enum logic [2:0] {
        ST_ICW1, ST_ICW2, ST_ICW3, ST_ICW4, ST_RUN
    } pic_state_e;

    typedef struct packed {
        pic_state_e          st;
        logic [PIC_BW-1:0]   base;
        logic [PIC_NIN-1:0]  icw3;
        logic                casc_mode;
        logic                need4;
        logic                aeoi;
        logic [PIC_NIN-1:0]  mask;
        logic [PIC_NIN-1:0]  isr;
        logic                rd_isr;
        logic [PIC_DW-1:0]   vec;
        logic                vec_vld;
    } pic_regs_t;

    localparam pic_regs_t PIC_REGS_RST = '{
        st: ST_ICW1, base: '0, icw3: '0, casc_mode: 1'b0, need4: 1'b0,
        aeoi: 1'b0, mask: '1, isr: '0, rd_isr: 1'b0, vec: '0, vec_vld: 1'b0
    };
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] level_sel,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr_q
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q, irr_d;

        always_comb begin
            if (level_sel[g])
                irr_d = irq_in[g];
            else
                irr_d = (irr_q[g] | (irq_in[g] & ~prev_q)) & irq_in[g] & ~clr[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q   <= 1'b0;
                irr_q[g] <= 1'b0;
            end else begin
                prev_q   <= irq_in[g];
                irr_q[g] <= irr_d;
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [PIC_DW-1:0] wdata,
    output logic [PIC_DW-1:0] rdata,
    input  logic [PIC_NIN-1:0] irq_in,
    input  logic [PIC_NIN-1:0] level_sel,
    input  logic              is_master,
    input  logic              inta,
    output logic              int_out,
    output logic [PIC_DW-1:0] vec,
    output logic              vec_vld,
    output logic [PIC_IW-1:0] cas_id_out,
    output logic              cas_vld_out,
    input  logic [PIC_IW-1:0] cas_id_in,
    input  logic              cas_vld_in
);
    pic_regs_t q, d;

    logic [PIC_NIN-1:0] irr, clr, pend;
    logic               p_any, s_any, req_ok, selected, ack, take, casc, icw1_wr;
    logic [PIC_IW-1:0]  p_idx, s_idx;

    assign pend = irr & ~q.mask;

    pic_prio #(.N(PIC_NIN)) u_pend_prio (.bits(pend),  .any(p_any), .idx(p_idx));
    pic_prio #(.N(PIC_NIN)) u_isr_prio  (.bits(q.isr), .any(s_any), .idx(s_idx));

    assign req_ok   = p_any && (!s_any || (p_idx < s_idx));
    assign int_out  = req_ok && (q.st == ST_RUN);
    assign selected = is_master || (cas_vld_in && (cas_id_in == q.icw3[PIC_IW-1:0]));
    assign ack      = inta && (q.st == ST_RUN) && selected;
    assign take     = ack && req_ok;
    assign casc     = is_master && take && q.casc_mode && q.icw3[p_idx];
    assign icw1_wr  = wr_en && !addr && wdata[4];
    assign clr      = icw1_wr ? '1 : (take ? (PIC_NIN'(1) << p_idx) : '0);

    assign cas_vld_out = casc;
    assign cas_id_out  = casc ? p_idx : '0;

    pic_req #(.N(PIC_NIN)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel),
        .clr(clr), .irr_q(irr)
    );

    always_comb begin
        d = q;
        d.vec_vld = 1'b0;
        if (ack) begin
            d.vec_vld = !casc;
            d.vec     = {q.base, (take ? p_idx : PIC_IW'(PIC_NIN - 1))};
            if (take && !q.aeoi)
                d.isr[p_idx] = 1'b1;
        end
        if (wr_en && !addr) begin
            if (wdata[4]) begin
                d.st        = ST_ICW2;
                d.casc_mode = !wdata[1];
                d.need4     = wdata[0];
                d.aeoi      = 1'b0;
                d.isr       = '0;
                d.rd_isr    = 1'b0;
            end else if (q.st == ST_RUN) begin
                if (wdata[3]) begin
                    if (wdata[1])
                        d.rd_isr = wdata[0];
                end else begin
                    case (wdata[7:5])
                        3'b011: d.isr[wdata[PIC_IW-1:0]] = 1'b0;
                        3'b001: if (s_any) d.isr[s_idx] = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
        if (wr_en && addr) begin
            case (q.st)
                ST_ICW2: begin
                    d.base = wdata[PIC_DW-1:PIC_IW];
                    d.st   = q.casc_mode ? ST_ICW3 : (q.need4 ? ST_ICW4 : ST_RUN);
                end
                ST_ICW3: begin
                    d.icw3 = wdata;
                    d.st   = q.need4 ? ST_ICW4 : ST_RUN;
                end
                ST_ICW4: begin
                    d.aeoi = wdata[1];
                    d.st   = ST_RUN;
                end
                ST_RUN:  d.mask = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= PIC_REGS_RST;
        else        q <= d;
    end

    assign vec     = q.vec;
    assign vec_vld = q.vec_vld;
    assign rdata   = !rd_en ? '0 : (addr ? q.mask : (q.rd_isr ? q.isr : irr));

    p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(inta));
    p_aeoi_keeps_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && q.aeoi && !wr_en) |=> $stable(q.isr));
    p_spec_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && q.st == ST_RUN && wdata[7:3] == 5'b01100)
        |=> !q.isr[$past(wdata[PIC_IW-1:0])]);
    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out && !wr_en) |=> $stable(q.isr));
    p_mask_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ICW1 && wr_en && addr) |=> $stable(q.mask));
    p_cas_no_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cas_vld_out |=> !vec_vld);
endmodule

// File: tb/pic_core_bench.sv
`timescale 1ns/1ps
module pic_core_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       wr_m = 0, wr_s = 0, rd_en = 0, addr = 0, inta = 0;
    logic [7:0] wdata = 0, m_irq = 0, s_irq = 0, m_lvl = 0;
    logic [7:0] rdata_m, rdata_s, m_vec, s_vec;
    logic       m_int, s_int, m_vld, s_vld, m_cvld, s_cvld;
    logic [2:0] m_cid, s_cid;
    int tests = 0, fails = 0;
    logic [7:0] expq[$];

    pic_core u_pic_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_m), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_m), .irq_in({m_irq[7:3], s_int, m_irq[1:0]}),
        .level_sel(m_lvl), .is_master(1'b1), .inta(inta), .int_out(m_int),
        .vec(m_vec), .vec_vld(m_vld), .cas_id_out(m_cid), .cas_vld_out(m_cvld),
        .cas_id_in(3'd0), .cas_vld_in(1'b0));

    pic_core u_pic_slave (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_s), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_s), .irq_in(s_irq), .level_sel(8'h00),
        .is_master(1'b0), .inta(inta), .int_out(s_int), .vec(s_vec),
        .vec_vld(s_vld), .cas_id_out(s_cid), .cas_vld_out(s_cvld),
        .cas_id_in(m_cid), .cas_vld_in(m_cvld));

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit slv, logic a, logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v;
        if (slv) wr_s = 1; else wr_m = 1;
        @(negedge clk);
        wr_m = 0; wr_s = 0;
    endtask

    task automatic rd(bit slv, logic a, logic [7:0] exp, string req);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1;
        chk(req, slv ? rdata_s : rdata_m, exp);
        rd_en = 0;
    endtask

    task automatic ack(logic [7:0] exp);
        @(negedge clk);
        expq.push_back(exp);
        inta = 1;
        @(negedge clk);
        inta = 0;
    endtask

    // monitor: pops the scoreboard whenever either instance yields a vector
    always @(negedge clk) begin
        if (rst_n && (m_vld || s_vld)) begin
            if (m_vld && s_vld) begin
                tests++; fails++;
                $display("FAIL R11: both instances drove a vector, got 2 expected 1");
            end else if (expq.size() == 0) begin
                tests++; fails++;
                $display("FAIL R3: unexpected vector got %02h expected none", m_vld ? m_vec : s_vec);
            end else begin
                chk("R3 vector", m_vld ? m_vec : s_vec, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        rd(0, 1, 8'hFF, "R1 mask");
        rd(0, 0, 8'h00, "R1 irr");
        chk("R1 int_out", {7'd0, m_int}, 8'h00);
        // R2 data write before init ignored
        wr(0, 1, 8'h00);
        rd(0, 1, 8'hFF, "R2 pre-init mask");
        // init master: base 0x20, slave on 2, normal EOI
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        // init slave: base 0x28, identity 2
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        // R9 mask load/readback
        wr(0, 1, 8'h80); rd(0, 1, 8'h80, "R9 master mask");
        wr(1, 1, 8'h00); rd(1, 1, 8'h00, "R9 slave mask");
        // R4/R5/R8 priority between 3 and 5
        m_irq[3] = 1; m_irq[5] = 1; tick(2);
        chk("R4 int_out", {7'd0, m_int}, 8'h01);
        wr(0, 0, 8'h0A); rd(0, 0, 8'h28, "R8 irr select");
        ack(8'h23);
        wr(0, 0, 8'h0B); rd(0, 0, 8'h08, "R6 isr set");
        rd(0, 0, 8'h08, "R8 select persists");
        chk("R4 blocked by isr", {7'd0, m_int}, 8'h00);
        wr(0, 0, 8'h0A); rd(0, 0, 8'h20, "R5 edge cleared at ack");
        // R7 specific EOI
        wr(0, 0, 8'h63); wr(0, 0, 8'h0B); rd(0, 0, 8'h00, "R7 specific eoi");
        chk("R4 after eoi", {7'd0, m_int}, 8'h01);
        ack(8'h25);
        rd(0, 0, 8'h20, "R6 isr bit5");
        wr(0, 0, 8'h20); rd(0, 0, 8'h00, "R7 nonspecific eoi");
        m_irq[3] = 0; m_irq[5] = 0; tick(2);
        // R10 spurious: request vanishes before ack, input 7 masked
        m_irq[4] = 1; tick(2); m_irq[4] = 0; tick(2);
        wr(0, 0, 8'h0A); rd(0, 0, 8'h00, "R5 fall clears edge request");
        ack(8'h27);
        wr(0, 0, 8'h0B); rd(0, 0, 8'h00, "R10 isr unchanged");
        // R5 level-trigger tracking
        m_lvl[1] = 1; m_irq[1] = 1; tick(2);
        ack(8'h21);
        wr(0, 0, 8'h0A); rd(0, 0, 8'h02, "R5 level request held");
        wr(0, 0, 8'h61); m_irq[1] = 0; tick(2);
        rd(0, 0, 8'h00, "R5 level request follows input");
        // R11 cascade through slave input 6
        s_irq[6] = 1; tick(3);
        ack(8'h2E);
        wr(0, 0, 8'h0B); rd(0, 0, 8'h04, "R11 master cascade isr");
        wr(1, 0, 8'h0B); rd(1, 0, 8'h40, "R11 slave isr");
        wr(1, 0, 8'h66); wr(0, 0, 8'h62);
        rd(1, 0, 8'h00, "R11 slave eoi");
        rd(0, 0, 8'h00, "R11 master eoi");
        s_irq[6] = 0; tick(2);
        // R6 auto EOI after re-init
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
        rd(0, 1, 8'h80, "R9 mask across init");
        m_irq[0] = 1; tick(2);
        ack(8'h20);
        wr(0, 0, 8'h0B); rd(0, 0, 8'h00, "R6 auto eoi leaves isr");
        m_irq[0] = 0; tick(3);
        chk("R3 scoreboard drained", 8'(expq.size()), 8'h00);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule